// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block produces the bit timing for one serial channel from the peripheral clock. Software writes an 8-bit divisor and a small control word. The control word holds a prescaler exponent and a smart-card cycles-per-bit field. An input port selects one of three operating laws: asynchronous, clocked synchronous or smart-card. Each channel has its own instance, so every channel runs at its own rate.

Inside, a power-of-four prescaler feeds a divisor reload counter. That counter emits a base-clock enable. A post-divider then counts base-clock enables up to a one-cycle bit-tick strobe. The post-divider length depends on the mode and, in smart-card mode, on the cycles-per-bit field. That field includes the non-power-of-two value 372.

The block captures all settings at each bit boundary. A write during a bit period therefore never disturbs the period already in progress.

Top module: `bitrate_gen`

## Requirements
- R1: During reset and in the first cycle after it, neither strobe is asserted. After reset the divisor reads 0xFF and the control word reads 0x00, so the first bit period in mode 01 lasts 4 × 256 cycles.
- R2: Software can write and read both registers at any time. Select 0 is the divisor. Select 1 is the control word, with bits [1:0] as the clock-select field and bits [3:2] as the cycle field. Bits [7:4] of the control word are ignored on write and read as zero.
- R3: Clock-select values 00, 01, 10 and 11 set the exponent n to 0, 1, 2 and 3. This gives a prescale factor of 4^n.
- R4: In asynchronous mode, one bit period lasts 32 × 4^n × (N+1) clock cycles. Mode 00 selects asynchronous mode, and the reserved mode code 11 behaves the same way.
- R5: In clocked synchronous mode (mode 01), one bit period lasts 4 × 4^n × (N+1) clock cycles.
- R6: In smart-card mode (mode 10), one bit period lasts 2 × S × 4^n × (N+1) clock cycles. The cycle field values 00, 01, 10 and 11 select S = 32, 64, 372 and 256.
- R7: The base-clock enable pulses once every 4^n × (N+1) cycles, and every bit tick coincides with a base-clock enable. Each bit period holds exactly 32 base pulses in asynchronous mode, 4 in clocked synchronous mode and 2 × S in smart-card mode.
- R8: The bit tick is high for exactly one clock cycle per bit period.
- R9: A change to the divisor, control word or mode takes effect only at the next bit boundary. The period in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divisor, 1 control word |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 divisor, 1 control word |
| rd_data | output | 8 | Read data |
| mode | input | 2 | 00 asynchronous, 01 clocked synchronous, 10 smart-card, 11 as 00 |
| base_en | output | 1 | Base-clock enable pulse |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit period |

## Verification
The bench measures whole bit periods and counts base pulses for every mode and every exponent. The sampled divisor values include 0 and 255, and the smart-card sample includes 372 cycles per bit, where a power-of-two shortcut would give a wrong count. It rewrites the divisor a few cycles into a running period. A design that reloads at once would shorten that period instead of waiting for the boundary. It also checks the reset values and the masking of the unused control bits. Two more cases target single-cycle behaviour: a tick held for more than one cycle, and a first period that starts one cycle early or late after reset. Either would show up as a wrong count.

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
  parameter int DIV_W  = 8,
  parameter int PRE_W  = 6,
  parameter int POST_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [DIV_W-1:0] rd_data,
  input  logic [1:0]       mode,
  output logic             base_en,
  output logic             bit_tick
);

  logic [DIV_W-1:0]  div_q, sh_div, div_cnt;
  logic [1:0]        cks_q, cyc_q, sh_cks;
  logic [POST_W-1:0] sh_post, post_cnt;
  logic [PRE_W-1:0]  pre_cnt, pre_lim;
  logic              start_q, pre_tick, load;

  function automatic logic [POST_W-1:0] post_len(input logic [1:0] m, input logic [1:0] c);
    case (m)
      2'b01:   return POST_W'(4);
      2'b10:
        case (c)
          2'b00:   return POST_W'(64);
          2'b01:   return POST_W'(128);
          2'b10:   return POST_W'(744);
          default: return POST_W'(512);
        endcase
      default: return POST_W'(32);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '1;
      cks_q <= '0;
      cyc_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) {cyc_q, cks_q} <= wr_data[3:0];
      else        div_q          <= wr_data;
    end

  assign rd_data = rd_sel ? {{(DIV_W-4){1'b0}}, cyc_q, cks_q} : div_q;

  assign pre_lim  = PRE_W'((7'd1 << {sh_cks, 1'b0}) - 7'd1);
  assign pre_tick = !start_q && (pre_cnt == pre_lim);
  assign base_en  = pre_tick && (div_cnt == sh_div);
  assign bit_tick = base_en && (post_cnt == sh_post - POST_W'(1));
  assign load     = start_q || bit_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q  <= 1'b1;
      sh_div   <= '1;
      sh_cks   <= '0;
      sh_post  <= POST_W'(32);
      pre_cnt  <= '0;
      div_cnt  <= '0;
      post_cnt <= '0;
    end else begin
      start_q <= 1'b0;
      if (load) begin
        sh_div   <= div_q;
        sh_cks   <= cks_q;
        sh_post  <= post_len(mode, cyc_q);
        pre_cnt  <= '0;
        div_cnt  <= '0;
        post_cnt <= '0;
      end else begin
        pre_cnt <= pre_tick ? '0 : pre_cnt + PRE_W'(1);
        if (pre_tick) div_cnt <= base_en ? '0 : div_cnt + DIV_W'(1);
        if (base_en)  post_cnt <= post_cnt + POST_W'(1);
      end
    end

endmodule

// File: rtl/bitrate_gen_chk.sv
module bitrate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_q,
  input logic       base_en,
  input logic       bit_tick,
  input logic [7:0] div_q,
  input logic [1:0] cks_q,
  input logic [1:0] cyc_q,
  input logic [1:0] mode
);

  logic [23:0] cnt, exp_len;
  logic [9:0]  bcnt, exp_b, per_bit;
  logic        valid;

  always_comb begin
    if (mode == 2'b01) per_bit = 10'd4;
    else if (mode == 2'b10)
      per_bit = (cyc_q == 2'b00) ? 10'd64 : (cyc_q == 2'b01) ? 10'd128 :
                (cyc_q == 2'b10) ? 10'd744 : 10'd512;
    else per_bit = 10'd32;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; exp_len <= '0; bcnt <= '0; exp_b <= '0; valid <= 1'b0;
    end else if (start_q || bit_tick) begin
      exp_len <= 24'(per_bit) * (24'd1 << {cks_q, 1'b0}) * (24'(div_q) + 24'd1);
      exp_b   <= per_bit;
      cnt     <= 24'd1;
      bcnt    <= '0;
      valid   <= 1'b1;
    end else begin
      cnt <= cnt + 24'd1;
      if (base_en) bcnt <= bcnt + 10'd1;
    end

  // R4 R5 R6 with settings frozen at the boundary
  p_period_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && bit_tick) |-> (cnt == exp_len));
  p_base_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && bit_tick) |-> (bcnt + 10'd1 == exp_b));
  p_tick_on_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_en);
  p_single_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
  p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (!bit_tick && !base_en));

endmodule

bind bitrate_gen bitrate_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_q(start_q), .base_en(base_en),
  .bit_tick(bit_tick), .div_q(div_q), .cks_q(cks_q), .cyc_q(cyc_q), .mode(mode)
);

// File: tb/bitrate_gen_tb_top.sv
`timescale 1ns/1ps
module bitrate_gen_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] mode = 2'b01;
  logic       base_en, bit_tick;
  int         total = 0, fails = 0;

  always #5 clk = ~clk;

  bitrate_gen dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .mode(mode),
    .base_en(base_en), .bit_tick(bit_tick));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic sel, input logic [7:0] expv, input string req);
    rd_sel = sel; #1;
    chk(rd_data == expv, req, "register read", rd_data, expv);
  endtask

  task automatic seek();
    while (!bit_tick) @(negedge clk);
  endtask

  task automatic measure(output int cyc, output int bases, input int poke_at, input logic [7:0] poke_val);
    cyc = 0; bases = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (poke_at != 0 && cyc == poke_at) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = poke_val;
      end else wr_en = 1'b0;
      if (base_en) bases++;
      if (cyc == 1) chk(!bit_tick, "R8", "tick after boundary", bit_tick, 0);
    end while (!bit_tick);
  endtask

  function automatic int law(input logic [1:0] m, input int n, input int s, input int dv);
    int per;
    if (m == 2'b01) per = 4;
    else if (m == 2'b10) per = 2 * s;
    else per = 32;
    return per * (4 ** n) * (dv + 1);
  endfunction

  function automatic int bases_of(input logic [1:0] m, input int s);
    return (m == 2'b01) ? 4 : (m == 2'b10) ? 2 * s : 32;
  endfunction

  function automatic logic [1:0] s_code(input int s);
    return (s == 64) ? 2'b01 : (s == 372) ? 2'b10 : (s == 256) ? 2'b11 : 2'b00;
  endfunction

  task automatic run_case(input string req, input logic [1:0] m, input int n, input int s, input int dv);
    int cyc, bases;
    @(negedge clk); mode = m;
    wr(1'b1, {4'b0, s_code(s), 2'(n)});
    wr(1'b0, 8'(dv));
    seek();
    measure(cyc, bases, 0, 8'h00);
    chk(cyc == law(m, n, s, dv), req, "bit period", cyc, law(m, n, s, dv));
    chk(bases == bases_of(m, s), "R7", "base pulses per bit", bases, bases_of(m, s));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rd_chk(1'b0, 8'hFF, "R1");
    rd_chk(1'b1, 8'h00, "R1");
    chk(!bit_tick && !base_en, "R1", "strobes in reset", {bit_tick, base_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bit_tick && !base_en, "R1", "strobes in start cycle", {bit_tick, base_en}, 0);
  endtask

  task automatic t_first_period();
    int cyc, bases;
    cyc = 1;
    while (!bit_tick) begin @(negedge clk); cyc++; end
    chk(cyc == 1024, "R1", "first period after reset", cyc, 1024);
  endtask

  task automatic t_regs();
    wr(1'b1, 8'hF5); rd_chk(1'b1, 8'h05, "R2");
    wr(1'b0, 8'h5A); rd_chk(1'b0, 8'h5A, "R2");
    rd_chk(1'b1, 8'h05, "R2");
  endtask

  task automatic t_async();
    run_case("R4/R3", 2'b00, 0, 0, 0);
    run_case("R4/R3", 2'b00, 1, 0, 2);
    run_case("R4/R3", 2'b00, 2, 0, 1);
    run_case("R4/R3", 2'b00, 3, 0, 0);
    run_case("R4", 2'b11, 0, 0, 1);
  endtask

  task automatic t_sync();
    run_case("R5/R3", 2'b01, 0, 0, 0);
    run_case("R5", 2'b01, 0, 0, 255);
    run_case("R5/R3", 2'b01, 1, 0, 5);
    run_case("R5/R3", 2'b01, 2, 0, 3);
    run_case("R5/R3", 2'b01, 3, 0, 1);
  endtask

  task automatic t_smart();
    run_case("R6", 2'b10, 0, 32, 0);
    run_case("R6", 2'b10, 1, 64, 0);
    run_case("R6", 2'b10, 0, 372, 1);
    run_case("R6", 2'b10, 2, 256, 0);
    run_case("R6", 2'b10, 3, 372, 0);
  endtask

  task automatic t_midwrite();
    int cyc, bases;
    run_case("R5", 2'b01, 0, 0, 9);
    measure(cyc, bases, 5, 8'd1);
    chk(cyc == 40, "R9", "period with mid-period write", cyc, 40);
    measure(cyc, bases, 0, 8'h00);
    chk(cyc == 8, "R9", "period after boundary", cyc, 8);
    chk(bases == 4, "R9", "base pulses after boundary", bases, 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hang, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_first_period();
    t_regs();
    t_async();
    t_sync();
    t_smart();
    t_midwrite();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule